// File: doc/BRIEF.md
# Rotating Six-Way Priority Arbiter

This block chooses one winner among six request lines in a single cycle. The search is combinational. Line 0 is always searched first and line 5 always last. The four lines in between are searched in one of four rotated orders, picked by a two-bit select state. A per-line presence mask marks slots that are not wired. Those slots are skipped, so they can never win, whatever their request bit says.

The grant leaves the block as a stream beat. `gnt_valid_o` is high whenever some present line is requesting, and `gnt_idx_o` names the winner. The consumer takes the beat by raising `gnt_ready_i`. Back-pressure rules:
- While ready is low, the select state holds.
- So while ready is low, the offered index stays the same for as long as the request and presence inputs stay the same.
- The select state may change only on a clock edge where valid and ready are both high.
- On such an edge, if rotation is enabled, the select state steps once.

Software or a parent block can also load the select state directly through a write port. That write overrides the rotation step. The select state resets to 0.

Top module: `rot_prio_arb`

## Requirements
- R1: With select 0, lines are searched in the order 0,1,2,3,4,5.
- R2: With select 1, lines are searched in the order 0,2,3,4,1,5.
- R3: With select 2, lines are searched in the order 0,3,4,1,2,5.
- R4: With select 3, lines are searched in the order 0,4,1,2,3,5.
- R5: A line whose presence bit is 0 is skipped and never appears on `gnt_idx_o` while valid is high.
- R6: On an edge where valid, ready and `rot_en_i` are high and no write occurs, the select becomes (select+1) mod 4, whichever line won.
- R7: With `rot_en_i` low, an accepted grant leaves the select unchanged.
- R8: When no present line requests, `gnt_valid_o` is 0, `gnt_idx_o` is 0 and the select does not change.
- R9: During and after reset the select reads 0.
- R10: When `sel_wr_en_i` is high on an edge, the select takes `sel_wr_data_i`, even if a rotation step would also apply on that edge.
- R11: While ready is low, the select does not change, even with rotation enabled and a valid grant offered.
- R12: A present requesting line 0 always wins. Line 5 wins only when no other present line requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Request lines, bit n = line n |
| present_i | input | 6 | Slot presence mask, 1 = slot wired |
| rot_en_i | input | 1 | Step the select after each accepted grant |
| gnt_ready_i | input | 1 | Consumer accepts the grant beat |
| sel_wr_en_i | input | 1 | Load the select state this edge |
| sel_wr_data_i | input | 2 | Value to load into the select state |
| gnt_valid_o | output | 1 | A grant is offered |
| gnt_idx_o | output | 3 | Winning line number, 0 when idle |
| sel_o | output | 2 | Current select state |

## Verification
The search is tried in four ways, each under every select value:
- All lines requesting: this shows the head of each order.
- Sparse masks that leave out the head: these separate neighbouring positions in each order.
- Masks where line 5 requests alone or together with others: these show that line 5 is always last.
- Masks with absent slots, including all-absent: these show that presence is applied before the search, not after it.

Rotation is then driven through a full wrap of the select, with the winner changing at each step. It is then held back three ways, with rotation off, with ready low, and with no request, to tell a step from a hold. A final edge carries both a write and a rotation step, to show that the write wins.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

  // Line searched at position pos under select value sel.
  // Position 0 and the last position are fixed. The middle ones rotate.
  function automatic int unsigned slot_at(input int unsigned sel,
                                          input int unsigned pos,
                                          input int unsigned nreq);
    int unsigned mid;
    mid = nreq - 2;
    if (pos == 0) return 0;
    if (pos == nreq - 1) return nreq - 1;
    return 1 + ((pos - 1 + sel) % mid);
  endfunction

endpackage

// File: rtl/rpa_order_map.sv
module rpa_order_map #(
  parameter int unsigned NUM_REQ = 6,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [NUM_REQ-1:0]       req,
  input  logic [NUM_REQ-1:0]       present,
  output logic [NUM_REQ-1:0]       pos_req,
  output logic [NUM_REQ*IDX_W-1:0] pos_slot
);
  import rpa_pkg::*;

  localparam int unsigned NUM_SEL = 1 << SEL_W;

  logic [NUM_REQ-1:0] live;
  assign live = req & present;

  for (genvar p = 0; p < NUM_REQ; p++) begin : g_pos
    logic [IDX_W-1:0] slot_w;
    always_comb begin
      slot_w = '0;
      for (int s = 0; s < NUM_SEL; s++) begin
        if (sel == SEL_W'(s)) slot_w = IDX_W'(slot_at(s, p, NUM_REQ));
      end
    end
    assign pos_slot[p*IDX_W +: IDX_W] = slot_w;
    assign pos_req[p] = live[slot_w];
  end

endmodule

// File: rtl/rpa_first_pick.sv
module rpa_first_pick #(
  parameter int unsigned NUM_REQ = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_REQ-1:0]       pos_req,
  input  logic [NUM_REQ*IDX_W-1:0] pos_slot,
  output logic                     found,
  output logic [IDX_W-1:0]         winner
);
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int p = 0; p < NUM_REQ; p++) begin
      if (!found && pos_req[p]) begin
        found  = 1'b1;
        winner = pos_slot[p*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/rpa_sel_reg.sv
module rpa_sel_reg #(
  parameter int unsigned NUM_REQ = 6,
  parameter int unsigned SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             accept,
  input  logic             rot_en,
  output logic [SEL_W-1:0] sel_q
);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_REQ - 3);

  logic [SEL_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en)                 sel_d = wr_sel;
    else if (accept && rot_en) sel_d = (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  p_rotate_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rot_en && !wr_en && sel_q != SEL_LAST) |=> (sel_q == $past(sel_q) + 1'b1));

  p_rotate_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rot_en && !wr_en && sel_q == SEL_LAST) |=> (sel_q == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(accept && rot_en)) |=> $stable(sel_q));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel_q == $past(wr_sel)));
endmodule

// File: rtl/rot_prio_arb.sv
module rot_prio_arb #(
  parameter  int unsigned NUM_REQ = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_REQ),
  localparam int unsigned SEL_W   = $clog2(NUM_REQ - 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] present_i,
  input  logic               rot_en_i,
  input  logic               gnt_ready_i,
  input  logic               sel_wr_en_i,
  input  logic [SEL_W-1:0]   sel_wr_data_i,
  output logic               gnt_valid_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic [SEL_W-1:0]   sel_o
);
  localparam logic [NUM_REQ-1:0] BELOW_LAST = {1'b0, {(NUM_REQ-1){1'b1}}};
  localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(NUM_REQ - 1);

  logic [SEL_W-1:0]         sel_q;
  logic [NUM_REQ-1:0]       pos_req;
  logic [NUM_REQ*IDX_W-1:0] pos_slot;
  logic                     found;
  logic [IDX_W-1:0]         winner;

  rpa_order_map #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_map (
    .sel(sel_q), .req(req_i), .present(present_i),
    .pos_req(pos_req), .pos_slot(pos_slot)
  );

  rpa_first_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
    .pos_req(pos_req), .pos_slot(pos_slot), .found(found), .winner(winner)
  );

  rpa_sel_reg #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr_en_i), .wr_sel(sel_wr_data_i),
    .accept(found && gnt_ready_i), .rot_en(rot_en_i), .sel_q(sel_q)
  );

  assign gnt_valid_o = found;
  assign gnt_idx_o   = winner;
  assign sel_o       = sel_q;

  p_grant_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> (req_i[gnt_idx_o] && present_i[gnt_idx_o]));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & present_i) == '0) |-> (!gnt_valid_o && gnt_idx_o == '0));

  p_head_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[0] && present_i[0]) |-> (gnt_valid_o && gnt_idx_o == '0));

  p_tail_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && gnt_idx_o == LAST_IDX) |-> ((req_i & present_i & BELOW_LAST) == '0));
endmodule

// File: tb/tb_rot_prio_arb.sv
module tb_rot_prio_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] req_i, present_i;
  logic       rot_en_i, gnt_ready_i, sel_wr_en_i;
  logic [1:0] sel_wr_data_i;
  logic       gnt_valid_o;
  logic [2:0] gnt_idx_o;
  logic [1:0] sel_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_prio_arb dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .present_i(present_i),
    .rot_en_i(rot_en_i), .gnt_ready_i(gnt_ready_i), .sel_wr_en_i(sel_wr_en_i),
    .sel_wr_data_i(sel_wr_data_i), .gnt_valid_o(gnt_valid_o),
    .gnt_idx_o(gnt_idx_o), .sel_o(sel_o)
  );

  // {sel, present, req, expected valid, expected index}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 6'h3F, 6'h3E, 1'b1, 3'd1},  // R1
    {2'd0, 6'h3F, 6'h3C, 1'b1, 3'd2},  // R1
    {2'd1, 6'h3F, 6'h3E, 1'b1, 3'd2},  // R2
    {2'd1, 6'h3F, 6'h22, 1'b1, 3'd1},  // R2
    {2'd2, 6'h3F, 6'h3E, 1'b1, 3'd3},  // R3
    {2'd2, 6'h3F, 6'h26, 1'b1, 3'd1},  // R3
    {2'd2, 6'h3F, 6'h24, 1'b1, 3'd2},  // R3
    {2'd3, 6'h3F, 6'h3E, 1'b1, 3'd4},  // R4
    {2'd3, 6'h3F, 6'h2E, 1'b1, 3'd1},  // R4
    {2'd3, 6'h3F, 6'h08, 1'b1, 3'd3},  // R4
    {2'd2, 6'h3F, 6'h3F, 1'b1, 3'd0},  // R12
    {2'd1, 6'h3F, 6'h20, 1'b1, 3'd5},  // R12
    {2'd0, 6'h3D, 6'h3E, 1'b1, 3'd2},  // R5
    {2'd3, 6'h2F, 6'h3E, 1'b1, 3'd1},  // R5
    {2'd0, 6'h1E, 6'h21, 1'b0, 3'd0},  // R8
    {2'd2, 6'h3F, 6'h00, 1'b0, 3'd0},  // R8
    {2'd1, 6'h3E, 6'h01, 1'b0, 3'd0}   // R5
  };
  localparam int TAG [NV] = '{1,1,2,2,3,3,3,4,4,4,12,12,5,5,8,8,5};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_sel(input logic [1:0] s);
    sel_wr_en_i = 1'b1; sel_wr_data_i = s; gnt_ready_i = 1'b0;
    step();
    sel_wr_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = '0; present_i = '0; rot_en_i = 1'b0;
    gnt_ready_i = 1'b0; sel_wr_en_i = 1'b0; sel_wr_data_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 sel in reset", sel_o, 0);
    chk("R8 valid in reset", gnt_valid_o, 0);
    step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    chk("R9 sel after reset", sel_o, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      step();
      req_i = '0;
      load_sel(VEC[i][17:16]);
      present_i = VEC[i][15:10];
      req_i = VEC[i][9:4];
      rot_en_i = 1'b0;
      @(negedge clk);
      chk($sformatf("R%0d valid vec %0d", TAG[i], i), gnt_valid_o, VEC[i][3]);
      chk($sformatf("R%0d index vec %0d", TAG[i], i), gnt_idx_o, VEC[i][2:0]);
      chk($sformatf("R10 loaded sel vec %0d", i), sel_o, VEC[i][17:16]);
    end

    // R6: rotation through a full wrap, all middle lines requesting
    step();
    load_sel(2'd0);
    present_i = 6'h3F; req_i = 6'h3E; rot_en_i = 1'b1; gnt_ready_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 sel during rotation", sel_o, k);
      chk("R6 winner during rotation", gnt_idx_o, k + 1);
      step();
    end
    @(negedge clk);
    chk("R6 sel wraps to 0", sel_o, 0);
    // R6: line 5 wins, select still advances
    req_i = 6'h20;
    step();
    @(negedge clk);
    chk("R6 advance on line 5 win", sel_o, 1);

    // R7: rotation off
    req_i = 6'h3E; rot_en_i = 1'b0;
    step(); step();
    @(negedge clk);
    chk("R7 sel held", sel_o, 1);
    chk("R7 winner", gnt_idx_o, 2);

    // R11: ready low holds select
    rot_en_i = 1'b1; gnt_ready_i = 1'b0;
    step(); step();
    @(negedge clk);
    chk("R11 sel held without ready", sel_o, 1);
    chk("R11 offer stable", gnt_idx_o, 2);

    // R8: no request, nothing steps
    gnt_ready_i = 1'b1; req_i = 6'h00;
    step();
    @(negedge clk);
    chk("R8 sel held idle", sel_o, 1);
    chk("R8 index idle", gnt_idx_o, 0);
    present_i = 6'h00; req_i = 6'h3F;
    step();
    @(negedge clk);
    chk("R8 sel held all absent", sel_o, 1);
    chk("R8 valid all absent", gnt_valid_o, 0);

    // R10: write beats rotation
    present_i = 6'h3F; req_i = 6'h3E;
    sel_wr_en_i = 1'b1; sel_wr_data_i = 2'd3;
    step();
    sel_wr_en_i = 1'b0; gnt_ready_i = 1'b0;
    @(negedge clk);
    chk("R10 write over rotation", sel_o, 3);

    // R12: line 0 wins under every select
    rot_en_i = 1'b0;
    for (int s = 0; s < 4; s++) begin
      load_sel(2'(s));
      req_i = 6'h21;
      @(negedge clk);
      chk("R12 line 0 first", gnt_idx_o, 0);
      req_i = 6'h30;
      @(negedge clk);
      chk("R12 line 5 last", gnt_idx_o, 4);
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule